// File: doc/BRIEF.md
# Custom-Sequence JK Synchronous Counter

This block is a 4-bit synchronous counter that walks a fixed, non-binary cycle instead of counting in binary. Out of code 0 it moves to 1 and then loops 1, 2, 4, 8, 9, back to 1, forever. Each state bit sits in its own JK flip-flop. The J and K inputs come from a minimised excitation network made only of NAND gates, with inverters built as single-input NANDs. All flip-flops share one clock edge.

Any code outside the loop (3, 5, 6, 7 and 10 to 15) is forced to 1 on the next counting edge, so the counter cannot lock up. A count enable freezes the state by driving every J and K low. A debug load port writes any code straight into the flip-flops, so each of the 16 codes can be placed and stepped once. A wrap pulse marks the cycle in which the counter leaves 9 for 1.

The pins are plain control and status wires. No data stream enters or leaves the block, so there is no valid/ready handshake and no back-pressure.

Top module: `jkc_seq_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, `state_q` becomes 0000 after that edge. This wins over `ld` and `en`.
- R2: When `rst` is low and `ld` is high at an edge, `state_q` takes the value of `ld_val` after that edge, whatever `en` and the current code are.
- R3: When `rst`, `ld` and `en` are all low at an edge, `state_q` keeps its value.
- R4: With `en` high (and `rst`, `ld` low), code 0 steps to code 1.
- R5: With `en` high, the loop codes step 1 to 2, 2 to 4, 4 to 8, 8 to 9 and 9 to 1, where `state_q[0]` is bit A (least significant) and `state_q[3]` is bit D.
- R6: With `en` high, each of the unused codes 3, 5, 6, 7, 10, 11, 12, 13, 14 and 15 steps to 1 in a single edge.
- R7: `wrap` is high, combinationally, exactly when `state_q` is 9, `en` is high, and `rst` and `ld` are both low.
- R8: While `en` is low, every J and K input of the four flip-flops is 0, so counting has no effect on the stored code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared rising-edge clock for all flip-flops |
| rst | input | 1 | Synchronous active-high reset to code 0 |
| en | input | 1 | Count enable; low holds the state |
| ld | input | 1 | Debug load strobe, below reset in priority |
| ld_val | input | 4 | Code written by the debug load |
| state_q | output | 4 | Current code, bit 0 = A, bit 3 = D |
| wrap | output | 1 | High while the counter is about to step from 9 to 1 |

## Verification
Two events can fall in the same cycle: a counting step with a wrap out of code 9, and a debug load or reset. The bench provokes this by holding the counter at 9 with `en` high while it raises `ld` with another code. In a second case it raises `rst` together with `ld`. In each case it expects `wrap` to stay low in that cycle and the next code to come from the winning control, not from the counting sequence. A table walk also loads each of the 16 codes, steps it once and compares the result with a next-state table the bench holds on its own.

// File: rtl/jkc_pkg.sv
package jkc_pkg;
  localparam int STATE_W = 4;
  typedef logic [STATE_W-1:0] code_t;
  localparam code_t CODE_ENTRY = code_t'(1);
  localparam code_t CODE_WRAP  = code_t'(9);
  localparam int BIT_A = 0;
  localparam int BIT_B = 1;
  localparam int BIT_C = 2;
  localparam int BIT_D = 3;
endpackage

// File: rtl/jkc_nand.sv
module jkc_nand #(
  parameter int N = 2
) (
  input  logic [N-1:0] a,
  output logic         y
);
  assign y = ~&a;
endmodule

// File: rtl/jkc_jkff.sv
module jkc_jkff (
  input  logic clk,
  input  logic rst,
  input  logic ld,
  input  logic d,
  input  logic j,
  input  logic k,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (ld)  q <= d;
    else begin
      case ({j, k})
        2'b10:   q <= 1'b1;
        2'b01:   q <= 1'b0;
        2'b11:   q <= ~q;
        default: q <= q;
      endcase
    end
  end
endmodule

// File: rtl/jkc_excite.sv
module jkc_excite
  import jkc_pkg::*;
(
  input  code_t q,
  input  logic  en,
  input  logic  rst,
  input  logic  ld,
  output code_t j,
  output code_t k,
  output logic  wrap
);
  code_t qn;
  logic en_n, rst_n, ld_n;

  // single-input NANDs serve as inverters
  for (genvar i = 0; i < STATE_W; i++) begin : g_inv
    jkc_nand #(.N(1)) u_inv (.a(q[i]), .y(qn[i]));
  end
  jkc_nand #(.N(1)) u_inv_en  (.a(en),  .y(en_n));
  jkc_nand #(.N(1)) u_inv_rst (.a(rst), .y(rst_n));
  jkc_nand #(.N(1)) u_inv_ld  (.a(ld),  .y(ld_n));

  // Bit A: J = en & (D | ~(B^C)), K = en & ~D & ~C & ~B
  logic x1, x2, x_bc, ja_or, ja_n, ka_n;
  jkc_nand #(.N(2)) u_x1 (.a({q[BIT_B], qn[BIT_C]}), .y(x1));
  jkc_nand #(.N(2)) u_x2 (.a({qn[BIT_B], q[BIT_C]}), .y(x2));
  jkc_nand #(.N(2)) u_x3 (.a({x1, x2}), .y(x_bc));
  jkc_nand #(.N(2)) u_jao (.a({qn[BIT_D], x_bc}), .y(ja_or));
  jkc_nand #(.N(2)) u_jan (.a({en, ja_or}), .y(ja_n));
  jkc_nand #(.N(1)) u_ja  (.a(ja_n), .y(j[BIT_A]));
  jkc_nand #(.N(4)) u_kan (.a({en, qn[BIT_D], qn[BIT_C], qn[BIT_B]}), .y(ka_n));
  jkc_nand #(.N(1)) u_ka  (.a(ka_n), .y(k[BIT_A]));

  // Bit B: J = en & ~D & ~C & A, K = en
  logic jb_n;
  jkc_nand #(.N(4)) u_jbn (.a({en, qn[BIT_D], qn[BIT_C], q[BIT_A]}), .y(jb_n));
  jkc_nand #(.N(1)) u_jb  (.a(jb_n), .y(j[BIT_B]));
  jkc_nand #(.N(1)) u_kb  (.a(en_n), .y(k[BIT_B]));

  // Bit C: J = en & ~D & B & ~A, K = en
  logic jc_n;
  jkc_nand #(.N(4)) u_jcn (.a({en, qn[BIT_D], q[BIT_B], qn[BIT_A]}), .y(jc_n));
  jkc_nand #(.N(1)) u_jc  (.a(jc_n), .y(j[BIT_C]));
  jkc_nand #(.N(1)) u_kc  (.a(en_n), .y(k[BIT_C]));

  // Bit D: J = en & C & ~B & ~A, K = en & (A | B | C)
  logic jd_n, kd_or, kd_n;
  jkc_nand #(.N(4)) u_jdn (.a({en, q[BIT_C], qn[BIT_B], qn[BIT_A]}), .y(jd_n));
  jkc_nand #(.N(1)) u_jd  (.a(jd_n), .y(j[BIT_D]));
  jkc_nand #(.N(3)) u_kdo (.a({qn[BIT_A], qn[BIT_B], qn[BIT_C]}), .y(kd_or));
  jkc_nand #(.N(2)) u_kdn (.a({en, kd_or}), .y(kd_n));
  jkc_nand #(.N(1)) u_kd  (.a(kd_n), .y(k[BIT_D]));

  // wrap: counting step out of code 9, not overridden by reset or load
  logic wrap_n;
  jkc_nand #(.N(7)) u_wrn (
    .a({en, rst_n, ld_n, q[BIT_D], qn[BIT_C], qn[BIT_B], q[BIT_A]}),
    .y(wrap_n));
  jkc_nand #(.N(1)) u_wr (.a(wrap_n), .y(wrap));
endmodule

// File: rtl/jkc_seq_counter.sv
module jkc_seq_counter
  import jkc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               ld,
  input  logic [STATE_W-1:0] ld_val,
  output logic [STATE_W-1:0] state_q,
  output logic               wrap
);
  code_t j, k;

  jkc_excite u_excite (
    .q(state_q), .en(en), .rst(rst), .ld(ld),
    .j(j), .k(k), .wrap(wrap));

  for (genvar i = 0; i < STATE_W; i++) begin : g_ff
    jkc_jkff u_ff (
      .clk(clk), .rst(rst), .ld(ld), .d(ld_val[i]),
      .j(j[i]), .k(k[i]), .q(state_q[i]));
  end
endmodule

// File: rtl/jkc_seq_counter_chk.sv
module jkc_seq_counter_chk
  import jkc_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  en,
  input logic  ld,
  input code_t ld_val,
  input code_t state_q,
  input logic  wrap,
  input code_t j,
  input code_t k
);
  function automatic code_t seq_next(input code_t c);
    case (c)
      4'd0:    return 4'd1;
      4'd1:    return 4'd2;
      4'd2:    return 4'd4;
      4'd4:    return 4'd8;
      4'd8:    return 4'd9;
      default: return CODE_ENTRY;
    endcase
  endfunction

  logic counting;
  assign counting = !rst && !ld && en;

  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> state_q == '0);

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    ld |=> state_q == $past(ld_val));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!ld && !en) |=> $stable(state_q));

  p_start_r4: assert property (@(posedge clk) disable iff (rst)
    (counting && state_q == '0) |=> state_q == CODE_ENTRY);

  p_loop_r5: assert property (@(posedge clk) disable iff (rst)
    (counting && $countones(state_q) == 1) |=> state_q == seq_next($past(state_q)));

  p_wrap_step_r5: assert property (@(posedge clk) disable iff (rst)
    (counting && state_q == CODE_WRAP) |=> state_q == CODE_ENTRY);

  p_recover_r6: assert property (@(posedge clk) disable iff (rst)
    (counting && state_q != '0 && state_q != CODE_WRAP && $countones(state_q) != 1)
      |=> state_q == CODE_ENTRY);

  p_wrap_flag_r7: assert property (@(posedge clk) disable iff (rst)
    wrap == (counting && state_q == CODE_WRAP));

  p_quiet_jk_r8: assert property (@(posedge clk) disable iff (rst)
    !en |-> (j == '0 && k == '0));
endmodule

bind jkc_seq_counter jkc_seq_counter_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .ld(ld), .ld_val(ld_val),
  .state_q(state_q), .wrap(wrap), .j(j), .k(k));

// File: tb/jkc_seq_counter_tb.sv
module jkc_seq_counter_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       ld = 1'b0;
  logic [3:0] ld_val = 4'd0;
  logic [3:0] state_q;
  logic       wrap;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  jkc_seq_counter u_dut (
    .clk(clk), .rst(rst), .en(en), .ld(ld), .ld_val(ld_val),
    .state_q(state_q), .wrap(wrap));

  // {code loaded, expected code after one counting step}
  localparam logic [7:0] VEC [16] = '{
    8'h01, 8'h12, 8'h24, 8'h31, 8'h48, 8'h51, 8'h61, 8'h71,
    8'h89, 8'h91, 8'hA1, 8'hB1, 8'hC1, 8'hD1, 8'hE1, 8'hF1};

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    step();
    chk("R1 reset state", state_q, 4'd0);
    chk("R7 no wrap in reset", {3'b0, wrap}, 4'd0);
    rst = 1'b0;

    // R4/R5 walk from reset with wrap observed
    en = 1'b1;
    begin
      logic [3:0] walk [7] = '{4'd1, 4'd2, 4'd4, 4'd8, 4'd9, 4'd1, 4'd2};
      for (int i = 0; i < 7; i++) begin
        chk("R7 wrap before step", {3'b0, wrap}, {3'b0, state_q == 4'd9});
        step();
        chk(i == 0 ? "R4 0 to 1" : "R5 loop", state_q, walk[i]);
      end
    end
    en = 1'b0;

    // table walk: load every code, step once (R2, R4, R5, R6, R7)
    for (int v = 0; v < 16; v++) begin
      ld = 1'b1; ld_val = VEC[v][7:4]; en = 1'b0;
      step();
      ld = 1'b0;
      chk("R2 load", state_q, VEC[v][7:4]);
      en = 1'b1;
      #0.5;
      chk("R7 wrap level", {3'b0, wrap}, {3'b0, VEC[v][7:4] == 4'd9});
      step();
      en = 1'b0;
      chk((VEC[v][3:0] == 4'd1 && VEC[v][7:4] != 4'd0 && VEC[v][7:4] != 4'd9)
            ? "R6 recover" : "R5 next", state_q, VEC[v][3:0]);
    end

    // R3/R8 hold with enable low
    ld = 1'b1; ld_val = 4'd4;
    step();
    ld = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R3 R8 hold", state_q, 4'd4);
    end
    ld = 1'b1; ld_val = 4'd9;
    step();
    ld = 1'b0;
    step();
    chk("R3 hold at 9", state_q, 4'd9);
    chk("R7 no wrap when idle", {3'b0, wrap}, 4'd0);

    // same cycle: wrap condition plus load (R2 wins, R7 low)
    en = 1'b1; ld = 1'b1; ld_val = 4'd6;
    #0.5;
    chk("R7 wrap masked by load", {3'b0, wrap}, 4'd0);
    step();
    ld = 1'b0; en = 1'b0;
    chk("R2 load beats count", state_q, 4'd6);

    // reset beats load and count (R1)
    ld = 1'b1; ld_val = 4'd9;
    step();
    rst = 1'b1; ld = 1'b1; ld_val = 4'd5; en = 1'b1;
    #0.5;
    chk("R7 wrap masked by reset", {3'b0, wrap}, 4'd0);
    step();
    chk("R1 reset priority", state_q, 4'd0);
    rst = 1'b0; ld = 1'b0; en = 1'b0;
    step();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule